// File: doc/BRIEF.md
# Quad-Tap Pixel Address Generator

This block sits between four analog-to-digital converter channels and a frame buffer. The image sensor in front of it has four output taps, one per quadrant, and all four taps shift out in parallel. Each tap starts at the frame edges nearest to its quadrant and moves toward the centre. The top taps move down from row 0 and the bottom taps move up from the last row. The left taps move right from column 0 and the right taps move left from the last column. For every sample the block computes the (row, column) write address in the normal raster frame. The frame buffer can then be filled directly, with no reordering afterwards.

A shared pixel strobe, line strobe and frame strobe drive one scan position, and all four taps derive their addresses from it. The converters return each sample a fixed `LAT` cycles after its pixel strobe. The address and valid bits are delayed by the same amount so that each tuple leaves the block already paired with its sample. The frame width and height are parameters and must both be even. `LAT` must be at least 1.

Top module: `quad_tap_addr`

## Requirements
- R1: While reset is applied, and in the cycles after it until the first accepted pixel strobe has come through the pipeline, every bit of `out_valid` is 0.
- R2: Tap 0 covers the upper-left quadrant. For scan position (line l, pixel c) its address is row l, column c.
- R3: Tap 1 covers the upper-right quadrant. Its address is row l, column IMG_W-1-c, so its column is the mirror of tap 0's column on the same row.
- R4: Tap 2 covers the lower-left quadrant. Its address is row IMG_H-1-l, column c.
- R5: Tap 3 covers the lower-right quadrant. Its address is row IMG_H-1-l, column IMG_W-1-c, so it falls in rows IMG_H/2 and up and in columns IMG_W/2 and up.
- R6: An accepted pixel strobe sampled at clock edge n produces an output tuple that is visible after edge n+LAT. The data word in that tuple is the tap input sampled at edge n+LAT. Tap t's data is lane t of `tap_data`, bits [t*DW +: DW].
- R7: A pixel strobe that arrives when IMG_W/2 pixels of the current line have already been accepted produces no valid output.
- R8: A pixel strobe that arrives when the line count has reached IMG_H/2 in the current frame produces no valid output. A line strobe does not advance the line count past IMG_H/2.
- R9: A line strobe returns the pixel position to 0 and advances the line position by one. Within a line, consecutive accepted pixels take consecutive scan positions.
- R10: A frame strobe returns both the pixel position and the line position to 0.
- R11: The strobes have a fixed priority: frame, then line, then pixel. A pixel strobe in the same cycle as a line or frame strobe is not accepted.
- R12: The four `out_valid` bits are always all 0 or all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pix_stb | input | 1 | Pixel strobe shared by all taps |
| line_stb | input | 1 | Line strobe shared by all taps |
| frame_stb | input | 1 | Frame strobe shared by all taps |
| tap_data | input | 4*DW | Converter samples; lane t is tap t |
| out_valid | output | 4 | Per-tap tuple valid |
| out_row | output | 4*RW | Per-tap row address, RW = clog2(IMG_H) |
| out_col | output | 4*CW | Per-tap column address, CW = clog2(IMG_W) |
| out_data | output | 4*DW | Per-tap sample paired with the address |

## Verification
Suppose a scan counter starts from the wrong value or steps wrongly. Every tap then writes to a shifted or mirrored address within LAT+1 cycles of the faulty strobe. When the whole frame is replayed into a model buffer, some cells are written twice and some are never written. If the delay line is one stage too long or too short, each sample is paired with the pattern of its neighbouring strobe, and the very first tuple after the fault shows a data mismatch. A missing bound on either counter shows up as a valid tuple on an ignored strobe, LAT+1 cycles after that strobe.

// File: rtl/qta_pkg.sv
package qta_pkg;
  localparam int NTAP = 4;

  // Tap index encoding: bit 0 = right half, bit 1 = bottom half.
  function automatic bit tap_is_right(input int t);
    return (t % 2) == 1;
  endfunction

  function automatic bit tap_is_bottom(input int t);
    return t >= 2;
  endfunction
endpackage

// File: rtl/qta_scan_ctr.sv
module qta_scan_ctr #(
  parameter int HALF_W = 4,
  parameter int HALF_H = 3,
  parameter int CIW    = 3,
  parameter int LIW    = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pix_stb,
  input  logic           line_stb,
  input  logic           frame_stb,
  output logic [CIW-1:0] col_idx,
  output logic [LIW-1:0] line_idx,
  output logic           hit
);
  localparam logic [CIW-1:0] COL_END  = CIW'(HALF_W);
  localparam logic [LIW-1:0] LINE_END = LIW'(HALF_H);

  logic [CIW-1:0] col_q, col_d;
  logic [LIW-1:0] line_q, line_d;
  logic           cnt_en;

  always_comb begin
    col_d  = col_q;
    line_d = line_q;
    hit    = 1'b0;
    if (frame_stb) begin
      col_d  = '0;
      line_d = '0;
    end else if (line_stb) begin
      col_d = '0;
      if (line_q < LINE_END) line_d = line_q + 1'b1;
    end else if (pix_stb && (col_q < COL_END) && (line_q < LINE_END)) begin
      hit   = 1'b1;
      col_d = col_q + 1'b1;
    end
  end

  assign cnt_en = frame_stb | line_stb | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      line_q <= '0;
    end else if (cnt_en) begin
      col_q  <= col_d;
      line_q <= line_d;
    end
  end

  assign col_idx  = col_q;
  assign line_idx = line_q;
endmodule

// File: rtl/qta_tap_map.sv
module qta_tap_map #(
  parameter bit MIRROR_COL = 1'b0,
  parameter bit MIRROR_ROW = 1'b0,
  parameter int IMG_W      = 8,
  parameter int IMG_H      = 6,
  parameter int CIW        = 3,
  parameter int LIW        = 2,
  parameter int CW         = 3,
  parameter int RW         = 3
) (
  input  logic [CIW-1:0] col_idx,
  input  logic [LIW-1:0] line_idx,
  output logic [RW-1:0]  row,
  output logic [CW-1:0]  col
);
  localparam logic [CW-1:0] COL_LAST = CW'(IMG_W - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(IMG_H - 1);

  generate
    if (MIRROR_COL) begin : g_col_mir
      assign col = COL_LAST - CW'(col_idx);
    end else begin : g_col_fwd
      assign col = CW'(col_idx);
    end
    if (MIRROR_ROW) begin : g_row_mir
      assign row = ROW_LAST - RW'(line_idx);
    end else begin : g_row_fwd
      assign row = RW'(line_idx);
    end
  endgenerate
endmodule

// File: rtl/qta_delay_line.sv
module qta_delay_line #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/quad_tap_addr.sv
module quad_tap_addr #(
  parameter int IMG_W = 8,
  parameter int IMG_H = 6,
  parameter int DW    = 8,
  parameter int LAT   = 3,
  parameter int CW    = $clog2(IMG_W),
  parameter int RW    = $clog2(IMG_H)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            pix_stb,
  input  logic                            line_stb,
  input  logic                            frame_stb,
  input  logic [qta_pkg::NTAP-1:0][DW-1:0] tap_data,
  output logic [qta_pkg::NTAP-1:0]        out_valid,
  output logic [qta_pkg::NTAP-1:0][RW-1:0] out_row,
  output logic [qta_pkg::NTAP-1:0][CW-1:0] out_col,
  output logic [qta_pkg::NTAP-1:0][DW-1:0] out_data
);
  import qta_pkg::*;

  localparam int HALF_W = IMG_W / 2;
  localparam int HALF_H = IMG_H / 2;
  localparam int CIW    = $clog2(HALF_W + 1);
  localparam int LIW    = $clog2(HALF_H + 1);
  localparam int PW     = 1 + RW + CW;

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rs_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  logic [CIW-1:0] col_idx;
  logic [LIW-1:0] line_idx;
  logic           hit;

  qta_scan_ctr #(
    .HALF_W(HALF_W), .HALF_H(HALF_H), .CIW(CIW), .LIW(LIW)
  ) u_scan (
    .clk(clk), .rst_n(core_rst_n),
    .pix_stb(pix_stb), .line_stb(line_stb), .frame_stb(frame_stb),
    .col_idx(col_idx), .line_idx(line_idx), .hit(hit)
  );

  generate
    for (genvar g = 0; g < NTAP; g++) begin : g_tap
      logic [RW-1:0] row_c;
      logic [CW-1:0] col_c;
      logic [PW-1:0] pipe_out;
      logic [DW-1:0] data_q;

      qta_tap_map #(
        .MIRROR_COL(tap_is_right(g)), .MIRROR_ROW(tap_is_bottom(g)),
        .IMG_W(IMG_W), .IMG_H(IMG_H), .CIW(CIW), .LIW(LIW), .CW(CW), .RW(RW)
      ) u_map (
        .col_idx(col_idx), .line_idx(line_idx), .row(row_c), .col(col_c)
      );

      // LAT+1 stages: the address is captured at the strobe edge and the
      // final stage lines up with the data register loaded LAT edges later.
      qta_delay_line #(.WIDTH(PW), .DEPTH(LAT + 1)) u_dly (
        .clk(clk), .rst_n(core_rst_n),
        .din({hit, row_c, col_c}), .dout(pipe_out)
      );

      always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) data_q <= '0;
        else             data_q <= tap_data[g];
      end

      assign out_valid[g] = pipe_out[PW-1];
      assign out_row[g]   = pipe_out[CW +: RW];
      assign out_col[g]   = pipe_out[0 +: CW];
      assign out_data[g]  = data_q;
    end
  endgenerate
endmodule

// File: rtl/qta_chk.sv
module qta_chk #(
  parameter int IMG_W = 8,
  parameter int IMG_H = 6,
  parameter int CW    = 3,
  parameter int RW    = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [3:0]            out_valid,
  input logic [3:0][RW-1:0]    out_row,
  input logic [3:0][CW-1:0]    out_col
);
  localparam logic [CW-1:0] COL_LAST = CW'(IMG_W - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(IMG_H - 1);
  localparam logic [CW-1:0] COL_MID  = CW'(IMG_W / 2);
  localparam logic [RW-1:0] ROW_MID  = RW'(IMG_H / 2);

  // R12
  all_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == 4'h0) || (out_valid == 4'hF));

  // R2
  tl_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[0] |-> (out_row[0] < ROW_MID) && (out_col[0] < COL_MID));

  // R3
  tr_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[1] |-> (out_col[1] == COL_LAST - out_col[0]) && (out_row[1] == out_row[0]));

  // R4
  bl_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[2] |-> (out_row[2] == ROW_LAST - out_row[0]) && (out_col[2] == out_col[0]));

  // R5
  br_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[3] |-> (out_row[3] >= ROW_MID) && (out_col[3] >= COL_MID));

  // R9
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid[0] && $past(out_valid[0]) && (out_row[0] == $past(out_row[0])))
      |-> (out_col[0] == CW'($past(out_col[0]) + 1'b1)));
endmodule

bind quad_tap_addr qta_chk #(
  .IMG_W(IMG_W), .IMG_H(IMG_H), .CW(CW), .RW(RW)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .out_valid(out_valid), .out_row(out_row), .out_col(out_col)
);

// File: tb/sim_quad_tap_addr.sv
module sim_quad_tap_addr;
  localparam int CLK_PERIOD = 10;
  localparam int IMG_W = 8;
  localparam int IMG_H = 6;
  localparam int DW    = 8;
  localparam int LAT   = 3;
  localparam int CW    = $clog2(IMG_W);
  localparam int RW    = $clog2(IMG_H);
  localparam int HW    = IMG_W / 2;
  localparam int HH    = IMG_H / 2;

  logic clk;
  logic rst_n;
  logic pix_stb, line_stb, frame_stb;
  logic [3:0][DW-1:0] tap_data;
  logic [3:0]         out_valid;
  logic [3:0][RW-1:0] out_row;
  logic [3:0][CW-1:0] out_col;
  logic [3:0][DW-1:0] out_data;

  int nchk, nerr, cyc;
  bit hist_ok [LAT+1];
  int hist_l  [LAT+1];
  int hist_c  [LAT+1];
  int wcnt [IMG_H][IMG_W];

  quad_tap_addr #(.IMG_W(IMG_W), .IMG_H(IMG_H), .DW(DW), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .line_stb(line_stb),
    .frame_stb(frame_stb), .tap_data(tap_data), .out_valid(out_valid),
    .out_row(out_row), .out_col(out_col), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      nerr++; nchk++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 50000", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  function automatic logic [DW-1:0] pat(int t, int l, int c);
    return {t[1:0], l[2:0], c[2:0]};
  endfunction

  task automatic check_out();
    bit ok = hist_ok[LAT];
    nchk++;
    if (out_valid !== (ok ? 4'hF : 4'h0)) begin
      nerr++;
      $display("FAIL R6 R7 R8 R11 R12: out_valid actual=%b expected=%b", out_valid, ok ? 4'hF : 4'h0);
    end
    if (ok && out_valid == 4'hF) begin
      for (int t = 0; t < 4; t++) begin
        int er = (t >= 2) ? IMG_H - 1 - hist_l[LAT] : hist_l[LAT];
        int ec = (t % 2 == 1) ? IMG_W - 1 - hist_c[LAT] : hist_c[LAT];
        nchk++;
        if (int'(out_row[t]) != er || int'(out_col[t]) != ec) begin
          nerr++;
          $display("FAIL R2 R3 R4 R5 tap%0d: addr actual=(%0d,%0d) expected=(%0d,%0d)",
                   t, out_row[t], out_col[t], er, ec);
        end
        nchk++;
        if (out_data[t] !== pat(t, hist_l[LAT], hist_c[LAT])) begin
          nerr++;
          $display("FAIL R6 tap%0d: data actual=%h expected=%h", t, out_data[t],
                   pat(t, hist_l[LAT], hist_c[LAT]));
        end
        if (int'(out_row[t]) < IMG_H && int'(out_col[t]) < IMG_W)
          wcnt[out_row[t]][out_col[t]]++;
      end
    end
  endtask

  task automatic step(bit p, bit ln, bit fr, bit ok, int l, int c);
    @(negedge clk);
    check_out();
    for (int i = LAT; i > 0; i--) begin
      hist_ok[i] = hist_ok[i-1]; hist_l[i] = hist_l[i-1]; hist_c[i] = hist_c[i-1];
    end
    hist_ok[0] = ok; hist_l[0] = l; hist_c[0] = c;
    pix_stb = p; line_stb = ln; frame_stb = fr;
    for (int t = 0; t < 4; t++)
      tap_data[t] = hist_ok[LAT] ? pat(t, hist_l[LAT], hist_c[LAT]) : 8'hFF;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic clear_mem();
    for (int r = 0; r < IMG_H; r++)
      for (int c = 0; c < IMG_W; c++) wcnt[r][c] = 0;
  endtask

  // One frame plus an extra pixel per line (R7) and an extra line (R8).
  task automatic scan(bit send_frame, bit gaps, bit pix_on_line);
    if (send_frame) step(0, 0, 1, 0, 0, 0);
    for (int l = 0; l <= HH; l++) begin
      for (int c = 0; c <= HW; c++) begin
        step(1, 0, 0, (c < HW) && (l < HH), l, c);
        if (gaps) idle(1);
      end
      // R9 line advance; R11 pixel coinciding with the line strobe
      step(pix_on_line, 1, 0, 0, 0, 0);
    end
    idle(LAT + 2);
  endtask

  task automatic check_mem(string tag);
    for (int r = 0; r < IMG_H; r++)
      for (int c = 0; c < IMG_W; c++) begin
        nchk++;
        if (wcnt[r][c] != 1) begin
          nerr++;
          $display("FAIL %s R2 R3 R4 R5: cell (%0d,%0d) writes actual=%0d expected=1",
                   tag, r, c, wcnt[r][c]);
        end
      end
  endtask

  initial begin
    nchk = 0; nerr = 0; cyc = 0;
    for (int i = 0; i <= LAT; i++) begin hist_ok[i] = 0; hist_l[i] = 0; hist_c[i] = 0; end
    pix_stb = 0; line_stb = 0; frame_stb = 0; tap_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    nchk++;
    if (out_valid !== 4'h0) begin
      nerr++; $display("FAIL R1: out_valid actual=%b expected=0000", out_valid);
    end
    rst_n = 1'b1;
    idle(4);

    // Back-to-back scan
    clear_mem();
    scan(1, 0, 0);
    check_mem("dense");

    // R10 R11: partial frame, then frame strobe with a pixel in the same cycle
    step(0, 0, 1, 0, 0, 0);
    for (int c = 0; c < 3; c++) step(1, 0, 0, 1, 0, c);
    step(0, 1, 0, 0, 0, 0);
    for (int c = 0; c < 2; c++) step(1, 0, 0, 1, 1, c);
    step(1, 0, 1, 0, 0, 0);
    idle(LAT + 2);
    clear_mem();
    scan(0, 1, 1);
    check_mem("restart");

    // Third frame, sparse strobes and a normal frame start
    clear_mem();
    scan(1, 1, 0);
    check_mem("sparse");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule